// File: doc/BRIEF.md
# Extended Integer Compare and Count Unit

This unit executes a small group of extension integer instructions on a 64-bit datapath. Each cycle it may accept one 32-bit instruction word together with the two source register values. It decodes the word and computes the result. One clock later it presents the destination register index, a write enable and the result value. The instruction group covers register and immediate equality tests, population count in word and doubleword widths, an unsigned byte add and the low half of a multiply.

The unit sits beside the main ALU in an execute stage. The register file reads both sources using the register fields of the word and writes back whatever the unit reports. A word that matches none of the listed encodings raises an illegal flag in place of a write, so the surrounding pipeline can trap it. A valid word whose destination is register 0 is legal and produces no write.

Top module: `ext_cmp_unit`

## Requirements
- R1: Every instruction needs the major opcode 011100 in bits 31:26; bits 25:21 name the first source (rs) and bits 20:16 the second (rt). A word with any other major opcode is illegal.
- R2: Function 101010 (equal) and 101011 (not equal) compare rs with rt, need bits 10:6 zero, and write to the register in bits 15:11 (rd). The result is 1 when the condition holds and 0 otherwise.
- R3: Function 101110 (equal) and 101111 (not equal) compare rs with the 10-bit immediate in bits 15:6, sign-extended to the datapath width. They write 1 or 0 to rt.
- R4: Bits 5:1 equal to 10110, with rt and bits 10:6 zero, select population count into rd. When bit 0 is 0 (word mode), only the low half of rs is counted.
- R5: Population count with bit 0 set (doubleword mode) counts every bit of rs.
- R6: Function 101000 with bits 10:6 zero writes (rs + rt) masked to its low 8 bits into rd.
- R7: Function 000011 with bits 10:6 zero writes the low 64 bits of rs*rt into rd.
- R8: A legal instruction whose destination index is 0 gives wr_en low, result zero and illegal low.
- R9: A valid word matching no encoding (including a nonzero bits 10:6 field where zero is needed, or a nonzero rt in population count) raises illegal, leaves wr_en low and gives result zero.
- R10: The outputs appear exactly one clock after the inputs are sampled with in_valid high. A cycle without in_valid gives out_valid, wr_en, illegal, wr_idx and result all zero on the next cycle.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are present |
| insn | input | 32 | Instruction word |
| rs_val | input | 64 | Value of the first source register |
| rt_val | input | 64 | Value of the second source register |
| out_valid | output | 1 | Result of the instruction accepted last cycle |
| wr_en | output | 1 | Write the result to the register file |
| wr_idx | output | 5 | Destination register index |
| result | output | 64 | Result value |
| illegal | output | 1 | Accepted word matches no encoding |

## Verification
The bench builds the unit with its default 64-bit datapath. With that width, the word-mode population count has to ignore a populated upper half. Products overflow 64 bits, so truncation is exercised. Immediates reach both ends of the signed 10-bit range against all-ones and small operands. Random words near the legal encodings also reach the decode boundaries: a stray bit in the shift field, a nonzero rt in population count, and a neighbouring function code.

// File: rtl/ext_cmp_unit.sv
module ext_cmp_unit #(
  parameter int          DATA_W   = 64,
  parameter logic [5:0]  MAJOR_OP = 6'b011100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic              out_valid,
  output logic              wr_en,
  output logic [4:0]        wr_idx,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  localparam int HALF_W = DATA_W / 2;
  localparam int IMM_W  = 10;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  function automatic logic [CNT_W-1:0] ones(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [5:0] major, fn;
  logic [4:0] rt_f, rd_f, sh_f;
  logic [IMM_W-1:0] imm;
  assign major = insn[31:26];
  assign rt_f  = insn[20:16];
  assign rd_f  = insn[15:11];
  assign sh_f  = insn[10:6];
  assign imm   = insn[15:6];
  assign fn    = insn[5:0];

  logic opc_ok, sh_zero;
  assign opc_ok  = (major == MAJOR_OP);
  assign sh_zero = (sh_f == 5'd0);

  logic is_req, is_rne, is_ieq, is_ine, is_pop, is_badd, is_mul;
  assign is_req  = opc_ok && sh_zero && fn == 6'b101010;
  assign is_rne  = opc_ok && sh_zero && fn == 6'b101011;
  assign is_ieq  = opc_ok && fn == 6'b101110;
  assign is_ine  = opc_ok && fn == 6'b101111;
  assign is_pop  = opc_ok && sh_zero && rt_f == 5'd0 && fn[5:1] == 5'b10110;
  assign is_badd = opc_ok && sh_zero && fn == 6'b101000;
  assign is_mul  = opc_ok && sh_zero && fn == 6'b000011;

  logic hit;
  assign hit = is_req | is_rne | is_ieq | is_ine | is_pop | is_badd | is_mul;

  logic [DATA_W-1:0] imm_ext, pop_src, mul_lo;
  logic [7:0]        badd;
  logic              reg_eq, imm_eq;
  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign reg_eq  = (rs_val == rt_val);
  assign imm_eq  = (rs_val == imm_ext);
  assign pop_src = fn[0] ? rs_val : {{(DATA_W-HALF_W){1'b0}}, rs_val[HALF_W-1:0]};
  assign badd    = rs_val[7:0] + rt_val[7:0];
  assign mul_lo  = rs_val * rt_val;

  logic [4:0]        dest;
  logic [DATA_W-1:0] value;
  always_comb begin
    dest  = rd_f;
    value = '0;
    if (is_req)       value = DATA_W'(reg_eq);
    else if (is_rne)  value = DATA_W'(!reg_eq);
    else if (is_ieq)  begin dest = rt_f; value = DATA_W'(imm_eq);  end
    else if (is_ine)  begin dest = rt_f; value = DATA_W'(!imm_eq); end
    else if (is_pop)  value = DATA_W'(ones(pop_src));
    else if (is_badd) value = DATA_W'(badd);
    else if (is_mul)  value = mul_lo;
  end

  logic do_wr;
  assign do_wr = in_valid && hit && dest != 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= do_wr;
      wr_idx    <= do_wr ? dest : 5'd0;
      result    <= do_wr ? value : '0;
      illegal   <= in_valid && !hit;
    end
  end

endmodule

// File: rtl/ext_cmp_unit_chk.sv
module ext_cmp_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [31:0]       insn,
  input logic              out_valid,
  input logic              wr_en,
  input logic [4:0]        wr_idx,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  p_suppress_zero_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx != 5'd0);

  p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && result == '0));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !illegal && result == '0));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && illegal));

  p_bad_major_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:26] != 6'b011100) |=> illegal);

  p_compare_bool_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:26] == 6'b011100 && insn[5:1] == 5'b10101) |=> result <= 1);

  p_imm_compare_bool_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:26] == 6'b011100 && insn[5:1] == 5'b10111) |=> result <= 1);

  p_word_pop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:26] == 6'b011100 && insn[5:0] == 6'b101100) |=> result <= DATA_W/2);

endmodule

bind ext_cmp_unit ext_cmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
  .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
  .result(result), .illegal(illegal)
);

// File: tb/ext_cmp_unit_bench.sv
module ext_cmp_unit_bench;
  localparam int W = 64;
  localparam logic [5:0] OPC = 6'b011100;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [W-1:0] rs_val = '0, rt_val = '0;
  logic out_valid, wr_en, illegal;
  logic [4:0] wr_idx;
  logic [W-1:0] result;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_cmp_unit u_ext_cmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid), .wr_en(wr_en),
    .wr_idx(wr_idx), .result(result), .illegal(illegal)
  );

  function automatic logic [31:0] enc(input logic [5:0] m, input logic [4:0] s, t, d, h,
                                      input logic [5:0] f);
    return {m, s, t, d, h, f};
  endfunction

  task automatic model(input logic v, input logic [31:0] w, input logic [W-1:0] a, b,
                       output logic e_we, output logic [4:0] e_idx,
                       output logic [W-1:0] e_res, output logic e_ill);
    logic ok; logic [4:0] dst; logic [W-1:0] val; logic [W-1:0] imm;
    logic shz;
    ok = 1'b0; dst = w[15:11]; val = '0;
    imm = W'($signed(w[15:6]));
    shz = (w[10:6] == 5'd0);
    if (w[31:26] == OPC) begin
      if (shz && w[5:0] == 6'b101010) begin ok = 1; val = W'(a == b); end
      else if (shz && w[5:0] == 6'b101011) begin ok = 1; val = W'(a != b); end
      else if (w[5:0] == 6'b101110) begin ok = 1; dst = w[20:16]; val = W'(a == imm); end
      else if (w[5:0] == 6'b101111) begin ok = 1; dst = w[20:16]; val = W'(a != imm); end
      else if (shz && w[20:16] == 0 && w[5:1] == 5'b10110) begin
        ok = 1; val = w[0] ? W'($countones(a)) : W'($countones(a[31:0]));
      end
      else if (shz && w[5:0] == 6'b101000) begin ok = 1; val = W'(8'(a + b)); end
      else if (shz && w[5:0] == 6'b000011) begin ok = 1; val = a * b; end
    end
    e_ill = v && !ok;
    e_we  = v && ok && dst != 0;
    e_idx = e_we ? dst : 5'd0;
    e_res = e_we ? val : '0;
  endtask

  task automatic check(input string req, input logic v, input logic e_we,
                       input logic [4:0] e_idx, input logic [W-1:0] e_res, input logic e_ill);
    compared++;
    if (out_valid !== v || wr_en !== e_we || wr_idx !== e_idx || result !== e_res || illegal !== e_ill) begin
      mismatched++;
      $display("FAIL %s: actual v=%b we=%b idx=%0d res=%h ill=%b expected v=%b we=%b idx=%0d res=%h ill=%b",
               req, out_valid, wr_en, wr_idx, result, illegal, v, e_we, e_idx, e_res, e_ill);
    end
  endtask

  task automatic apply(input string req, input logic v, input logic [31:0] w,
                       input logic [W-1:0] a, b);
    logic e_we, e_ill; logic [4:0] e_idx; logic [W-1:0] e_res;
    in_valid = v; insn = w; rs_val = a; rt_val = b;
    model(v, w, a, b, e_we, e_idx, e_res, e_ill);
    @(negedge clk);
    check(req, v, e_we, e_idx, e_res, e_ill);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11 reset", 1'b0, 1'b0, 5'd0, '0, 1'b0);
    rst_n = 1'b1;

    apply("R2 eq true",  1, enc(OPC, 1, 2, 3, 0, 6'b101010), 64'h1234, 64'h1234);
    apply("R2 ne false", 1, enc(OPC, 1, 2, 3, 0, 6'b101011), 64'h1234, 64'h1234);
    apply("R2 ne true",  1, enc(OPC, 1, 2, 7, 0, 6'b101011), 64'h1, 64'h2);
    apply("R3 imm -1",   1, {OPC, 5'd4, 5'd9, 10'h3FF, 6'b101110}, '1, 64'h0);
    apply("R3 imm -512", 1, {OPC, 5'd4, 5'd9, 10'h200, 6'b101110}, 64'hFFFF_FFFF_FFFF_FE00, 0);
    apply("R3 imm 511 ne", 1, {OPC, 5'd4, 5'd9, 10'h1FF, 6'b101111}, 64'd511, 0);
    apply("R4 pop word", 1, enc(OPC, 3, 0, 5, 0, 6'b101100), 64'hFFFF_FFFF_0000_00F0, 0);
    apply("R5 pop dword", 1, enc(OPC, 3, 0, 5, 0, 6'b101101), '1, 0);
    apply("R6 byte add wrap", 1, enc(OPC, 3, 4, 5, 0, 6'b101000), 64'h1FF, 64'h301);
    apply("R7 mul trunc", 1, enc(OPC, 3, 4, 5, 0, 6'b000011), 64'hFFFF_FFFF_FFFF_FFFF, 64'h3);
    apply("R8 rd zero", 1, enc(OPC, 3, 4, 0, 0, 6'b000011), 64'h5, 64'h7);
    apply("R8 rt zero imm", 1, {OPC, 5'd4, 5'd0, 10'h001, 6'b101110}, 64'd1, 0);
    apply("R1 bad major", 1, enc(6'b011111, 1, 2, 3, 0, 6'b101010), 0, 0);
    apply("R9 shift field", 1, enc(OPC, 1, 2, 3, 1, 6'b101010), 0, 0);
    apply("R9 pop rt set", 1, enc(OPC, 1, 2, 3, 0, 6'b101100), 64'hF, 0);
    apply("R9 unknown fn", 1, enc(OPC, 1, 2, 3, 0, 6'b101001), 0, 0);
    apply("R10 idle", 0, enc(OPC, 1, 2, 3, 0, 6'b000011), 64'h9, 64'h9);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] f; logic [31:0] w; logic [W-1:0] a, b; int k;
      k = $urandom_range(0, 9);
      case (k)
        0: f = 6'b101010; 1: f = 6'b101011; 2: f = 6'b101110; 3: f = 6'b101111;
        4: f = 6'b101100; 5: f = 6'b101101; 6: f = 6'b101000; 7: f = 6'b000011;
        default: f = 6'($urandom);
      endcase
      w = {OPC, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0, f};
      if ($urandom_range(0, 7) == 0) w[10:6] = 5'($urandom);
      if (k == 4 || k == 5) w[20:16] = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0;
      if ($urandom_range(0, 19) == 0) w[31:26] = 6'($urandom);
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      if (k == 2 || k == 3) begin
        if ($urandom_range(0, 1) == 0) a = W'($signed(w[15:6]));
      end
      apply("R1-R10 random", $urandom_range(0, 9) != 0, w, a, b);
    end

    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset again", 1'b0, 1'b0, 5'd0, '0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule